// File: doc/BRIEF.md
# Wake Event Detection Router

This block watches a group of asynchronous wake-up inputs and turns activity on them into latched events. Each input has a two-bit mode that selects what counts as an event: a low level, a high level, a falling edge or a rising edge. A detected event sets a sticky status bit. A per-input enable mask qualifies the status, and a single registered event output goes high whenever an enabled status bit is set. A power controller uses this output to leave a low-power state.

Software reaches the block over a simple register bus. The bus has a 12-bit byte address, a write strobe, write data, and read data that follows the address combinationally. Two read/write registers hold the mode bits. Status and enable can be read but not written directly. They change only through separate write-one-to-set and write-one-to-clear locations, so software never needs a read-modify-write.

Top module: `wake_event_router`

## Requirements
- R1: After reset the level configuration, edge configuration, enable and status registers are all zero, and `event_out` is low.
- R2: Input i is configured by bit i of the level register (offset 0x000) and bit i of the edge register (offset 0x004). With edge 0, level 0 detects a low level and level 1 detects a high level. With edge 1, level 0 detects a falling edge and level 1 detects a rising edge.
- R3: Every input passes through a two-flop synchronizer. An input change that meets a detection mode sets its status bit at the third rising clock edge after the change.
- R4: A detected event sets its status bit (offset 0xFE0, bit i) whether or not the input is enabled. The bit stays set until software clears it.
- R5: Writing 1 to bit i at offset 0xFDC sets enable bit i, and writing 1 to bit i at offset 0xFD8 clears it. Zero bits in the write data leave enable unchanged. Enable reads at offset 0xFE4.
- R6: Writing 1 to bit i at offset 0xFEC sets status bit i, and writing 1 to bit i at offset 0xFE8 clears it. Zero bits have no effect. When a hardware event and a clear land in the same cycle, the status bit stays set, so a level that persists re-sets its bit on every cycle.
- R7: Writes to the status offset (0xFE0) or the enable offset (0xFE4) change nothing.
- R8: The four set and clear offsets (0xFD8, 0xFDC, 0xFE8, 0xFEC) read back as zero.
- R9: `event_out` equals the OR over all inputs of status AND enable, registered once. A status or enable change shows on `event_out` one clock later.
- R10: Any offset not listed above reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_in | input | N_IN | Asynchronous wake-up inputs |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | N_IN | Write data, one bit per input |
| bus_rdata | output | N_IN | Read data for `bus_addr` |
| event_out | output | 1 | Registered OR of enabled status bits |

## Verification
The bench walks all sixteen combinations of mode and before/after input value on one input. An edge mode that fired on a level, or a swapped level polarity, would show up as a wrong status bit. A clear that lands while a level is still present must leave the bit set. A design where the clear won the collision would read zero there. The bench counts the synchronizer cycles exactly and checks `event_out` on both sides of its one-cycle lag, so a missing or extra register stage fails. Writes of zero, writes to read-only and reserved offsets, and reads of the set/clear locations are all checked through register reads. A decoder that aliased them onto live registers would corrupt a value the bench reads back.

// File: rtl/wer_pkg.sv
// Shared constants for the wake event router: register offsets and the
// per-input detection mode encoding ({edge bit, level bit}).
package wer_pkg;

    localparam int unsigned WER_ADDR_W = 12;

    localparam logic [WER_ADDR_W-1:0] OFS_LEVEL    = 12'h000;
    localparam logic [WER_ADDR_W-1:0] OFS_EDGE     = 12'h004;
    localparam logic [WER_ADDR_W-1:0] OFS_EN_CLR   = 12'hFD8;
    localparam logic [WER_ADDR_W-1:0] OFS_EN_SET   = 12'hFDC;
    localparam logic [WER_ADDR_W-1:0] OFS_STAT     = 12'hFE0;
    localparam logic [WER_ADDR_W-1:0] OFS_EN       = 12'hFE4;
    localparam logic [WER_ADDR_W-1:0] OFS_STAT_CLR = 12'hFE8;
    localparam logic [WER_ADDR_W-1:0] OFS_STAT_SET = 12'hFEC;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'b00,
        MODE_HIGH = 2'b01,
        MODE_FALL = 2'b10,
        MODE_RISE = 2'b11
    } wer_mode_e;

endpackage

// File: rtl/wer_sync.sv
// Synchronizer bank: STAGES flops per input, plus one more flop that holds
// the previous synchronized value for edge detection.
// Assumes: inputs are asynchronous single bits; STAGES >= 2.
module wer_sync #(
    parameter int unsigned N_IN   = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] async_in,
    output logic [N_IN-1:0] sync_out,
    output logic [N_IN-1:0] sync_prev
);

    logic [N_IN-1:0] chain [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage retimes the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

    // Delayed copy of the synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev <= '0;
        else        sync_prev <= sync_out;
    end

endmodule

// File: rtl/wer_detect.sv
// Per-input event detector. The {edge,level} configuration bits pick
// low level, high level, falling edge or rising edge.
// Assumes: sync and prev come from the same synchronizer, one cycle apart.
module wer_detect
    import wer_pkg::*;
#(
    parameter int unsigned N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] level_cfg,
    input  logic [N_IN-1:0] edge_cfg,
    input  logic [N_IN-1:0] sync,
    input  logic [N_IN-1:0] prev,
    output logic [N_IN-1:0] hit
);

    for (genvar i = 0; i < N_IN; i++) begin : g_det
        // Decode this input's mode into a one-cycle hit.
        always_comb begin
            case (wer_mode_e'({edge_cfg[i], level_cfg[i]}))
                MODE_LOW:  hit[i] = ~sync[i];
                MODE_HIGH: hit[i] = sync[i];
                MODE_FALL: hit[i] = prev[i] & ~sync[i];
                MODE_RISE: hit[i] = ~prev[i] & sync[i];
                default:   hit[i] = 1'b0;
            endcase
        end

        // R2: an edge-mode hit needs a change between sync and prev.
        a_r2_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_cfg[i] && hit[i]) |-> (sync[i] != prev[i]));
        // R2: a level-mode hit matches the selected polarity.
        a_r2_level_polarity: assert property (@(posedge clk) disable iff (!rst_n)
            (!edge_cfg[i] && hit[i]) |-> (sync[i] == level_cfg[i]));
    end

endmodule

// File: rtl/wer_regs.sv
// Register file: mode registers, write-one set/clear for enable and
// status, and a combinational read mux.
// Assumes: one write per bus_wr cycle; hardware hits beat software clears.
module wer_regs
    import wer_pkg::*;
#(
    parameter int unsigned N_IN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WER_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [N_IN-1:0]       bus_wdata,
    input  logic [N_IN-1:0]       hw_hit,
    output logic [N_IN-1:0]       level_cfg,
    output logic [N_IN-1:0]       edge_cfg,
    output logic [N_IN-1:0]       enable,
    output logic [N_IN-1:0]       status,
    output logic [N_IN-1:0]       bus_rdata
);

    logic wr_level, wr_edge, wr_en_set, wr_en_clr, wr_st_set, wr_st_clr;
    logic [N_IN-1:0] status_next;

    // Decode the write strobe per register.
    always_comb begin
        wr_level  = bus_wr && (bus_addr == OFS_LEVEL);
        wr_edge   = bus_wr && (bus_addr == OFS_EDGE);
        wr_en_set = bus_wr && (bus_addr == OFS_EN_SET);
        wr_en_clr = bus_wr && (bus_addr == OFS_EN_CLR);
        wr_st_set = bus_wr && (bus_addr == OFS_STAT_SET);
        wr_st_clr = bus_wr && (bus_addr == OFS_STAT_CLR);
    end

    // Mode configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_cfg <= '0;
            edge_cfg  <= '0;
        end else begin
            if (wr_level) level_cfg <= bus_wdata;
            if (wr_edge)  edge_cfg  <= bus_wdata;
        end
    end

    // Enable mask, changed only by the write-one set/clear locations.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable <= '0;
        else if (wr_en_set) enable <= enable | bus_wdata;
        else if (wr_en_clr) enable <= enable & ~bus_wdata;
    end

    // Next status: clear first, then software set, then hardware hits win.
    always_comb begin
        status_next = status;
        if (wr_st_clr) status_next = status_next & ~bus_wdata;
        if (wr_st_set) status_next = status_next | bus_wdata;
        status_next = status_next | hw_hit;
    end

    // Sticky status register.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_next;
    end

    // Read mux; set/clear and reserved locations read zero.
    always_comb begin
        case (bus_addr)
            OFS_LEVEL: bus_rdata = level_cfg;
            OFS_EDGE:  bus_rdata = edge_cfg;
            OFS_STAT:  bus_rdata = status;
            OFS_EN:    bus_rdata = enable;
            default:   bus_rdata = '0;
        endcase
    end

    // R5: bits written to the enable-set location are set next cycle.
    a_r5_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_set |=> ((enable & $past(bus_wdata)) == $past(bus_wdata)));
    // R5: enable only loses bits through the clear location.
    a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_clr |=> ((enable & $past(enable)) == $past(enable)));
    // R6: a hardware hit leaves its status bit set, even over a clear.
    a_r6_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_hit) |=> ((status & $past(hw_hit)) == $past(hw_hit)));
    // R6: status only loses bits through the clear location.
    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_st_clr |=> ((status & $past(status)) == $past(status)));
    // R7, R10: writes outside the mode locations keep the mode registers.
    a_r10_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_level && !wr_edge) |=>
            ($stable(level_cfg) && $stable(edge_cfg)));

endmodule

// File: rtl/wake_event_router.sv
// Top of the wake event router: synchronizer, detectors, register file
// and the registered combined event output.
// Assumes: a single clock domain for the bus; wake inputs are asynchronous.
module wake_event_router
    import wer_pkg::*;
#(
    parameter int unsigned N_IN        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_IN-1:0]       wake_in,
    input  logic [WER_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [N_IN-1:0]       bus_wdata,
    output logic [N_IN-1:0]       bus_rdata,
    output logic                  event_out
);

    logic [N_IN-1:0] sync_val, sync_prev, hit;
    logic [N_IN-1:0] level_cfg, edge_cfg, enable, status;

    wer_sync #(.N_IN(N_IN), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(wake_in),
        .sync_out(sync_val), .sync_prev(sync_prev)
    );

    wer_detect #(.N_IN(N_IN)) detect_i (
        .clk(clk), .rst_n(rst_n), .level_cfg(level_cfg), .edge_cfg(edge_cfg),
        .sync(sync_val), .prev(sync_prev), .hit(hit)
    );

    wer_regs #(.N_IN(N_IN)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .hw_hit(hit), .level_cfg(level_cfg),
        .edge_cfg(edge_cfg), .enable(enable), .status(status),
        .bus_rdata(bus_rdata)
    );

    // Registered OR of enabled status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) event_out <= 1'b0;
        else        event_out <= |(status & enable);
    end

    // R9: the event output follows enabled status with one cycle of lag.
    a_r9_event_lag: assert property (@(posedge clk) disable iff (!rst_n)
        event_out == $past(|(status & enable)));

endmodule

// File: tb/wake_event_router_tb_top.sv
module wake_event_router_tb_top;
    import wer_pkg::*;

    localparam int unsigned N = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    wake_in = '0;
    logic [11:0]     bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [N-1:0]    bus_wdata = '0;
    logic [N-1:0]    bus_rdata;
    logic            event_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wake_event_router #(.N_IN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .event_out(event_out)
    );

    // {edge, level, pre, post, expected status bit 0}
    localparam logic [4:0] VECS [16] = '{
        5'b00_00_1, 5'b00_01_1, 5'b00_10_1, 5'b00_11_0,
        5'b01_00_0, 5'b01_01_1, 5'b01_10_1, 5'b01_11_1,
        5'b10_00_0, 5'b10_01_0, 5'b10_10_1, 5'b10_11_0,
        5'b11_00_0, 5'b11_01_1, 5'b11_10_0, 5'b11_11_0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rd;
        idle(3);
        rst_n = 1'b1;
        #1;
        // R1: reset values
        chk("R1 event_out", {31'd0, event_out}, 32'd0);
        bus_read(OFS_LEVEL, rd); chk("R1 level", {24'd0, rd}, 32'd0);
        bus_read(OFS_EDGE, rd);  chk("R1 edge", {24'd0, rd}, 32'd0);
        bus_read(OFS_EN, rd);    chk("R1 enable", {24'd0, rd}, 32'd0);

        // R2 R4 R6 R9: vector walk on input 0 with enable bit 0 set
        bus_write(OFS_EN_SET, 8'h01);
        for (int v = 0; v < 16; v++) begin
            bus_write(OFS_EDGE, {7'd0, VECS[v][4]});
            bus_write(OFS_LEVEL, {7'd0, VECS[v][3]});
            wake_in[0] = VECS[v][2];
            idle(6);
            bus_write(OFS_STAT_CLR, 8'hFF);
            wake_in[0] = VECS[v][1];
            idle(6);
            bus_read(OFS_STAT, rd);
            chk($sformatf("R2 vec%0d status", v), {31'd0, rd[0]}, {31'd0, VECS[v][0]});
            chk($sformatf("R9 vec%0d event", v), {31'd0, event_out}, {31'd0, VECS[v][0]});
        end

        // R6: persisting low level beats a clear on every input
        wake_in = '0;
        bus_write(OFS_EDGE, 8'h00);
        bus_write(OFS_LEVEL, 8'h00);
        idle(5);
        bus_write(OFS_STAT_CLR, 8'hFF);
        bus_read(OFS_STAT, rd); chk("R6 set wins", {24'd0, rd}, 32'h0000_00FF);

        // R8: set/clear locations read zero
        bus_read(OFS_EN_SET, rd);   chk("R8 en_set", {24'd0, rd}, 32'd0);
        bus_read(OFS_EN_CLR, rd);   chk("R8 en_clr", {24'd0, rd}, 32'd0);
        bus_read(OFS_STAT_SET, rd); chk("R8 st_set", {24'd0, rd}, 32'd0);
        bus_read(OFS_STAT_CLR, rd); chk("R8 st_clr", {24'd0, rd}, 32'd0);

        // Quiet rising-edge mode on all inputs, then clear
        bus_write(OFS_EDGE, 8'hFF);
        bus_write(OFS_LEVEL, 8'hFF);
        idle(5);
        bus_write(OFS_STAT_CLR, 8'hFF);
        bus_write(OFS_EN_CLR, 8'hFF);
        bus_read(OFS_STAT, rd); chk("R6 cleared", {24'd0, rd}, 32'd0);
        bus_read(OFS_EN, rd);   chk("R5 cleared", {24'd0, rd}, 32'd0);

        // R6: software set, zero-write to clear ignored
        bus_write(OFS_STAT_SET, 8'h08);
        bus_write(OFS_STAT_CLR, 8'h00);
        bus_read(OFS_STAT, rd); chk("R6 sw set", {24'd0, rd}, 32'h08);
        // R4: status held though disabled, no event
        chk("R4 disabled event", {31'd0, event_out}, 32'd0);

        // R9: enable set; event one cycle after enable changes
        bus_write(OFS_EN_SET, 8'h08);
        #1 chk("R9 lag before", {31'd0, event_out}, 32'd0);
        @(negedge clk); #1 chk("R9 lag after", {31'd0, event_out}, 32'd1);
        // R5: zero write to set location has no effect
        bus_write(OFS_EN_CLR, 8'h00);
        bus_write(OFS_EN_SET, 8'h00);
        bus_read(OFS_EN, rd); chk("R5 zero write", {24'd0, rd}, 32'h08);

        // R7: writes to read-only views ignored
        bus_write(OFS_STAT, 8'hFF);
        bus_write(OFS_EN, 8'hFF);
        bus_read(OFS_STAT, rd); chk("R7 status ro", {24'd0, rd}, 32'h08);
        bus_read(OFS_EN, rd);   chk("R7 enable ro", {24'd0, rd}, 32'h08);

        // R10: reserved offsets
        bus_write(12'h008, 8'hFF);
        bus_write(12'h100, 8'h00);
        bus_write(12'hFD4, 8'hFF);
        bus_read(12'h100, rd);    chk("R10 read", {24'd0, rd}, 32'd0);
        bus_read(OFS_LEVEL, rd);  chk("R10 level", {24'd0, rd}, 32'hFF);
        bus_read(OFS_EDGE, rd);   chk("R10 edge", {24'd0, rd}, 32'hFF);
        bus_read(OFS_EN, rd);     chk("R10 enable", {24'd0, rd}, 32'h08);
        bus_read(OFS_STAT, rd);   chk("R10 status", {24'd0, rd}, 32'h08);

        // R5: clear enable drops the event one cycle later
        bus_write(OFS_EN_CLR, 8'h08);
        @(negedge clk); #1 chk("R5 en clr event", {31'd0, event_out}, 32'd0);

        // R3: rising edge on input 5 lands on the third clock edge
        bus_write(OFS_STAT_CLR, 8'hFF);
        @(negedge clk);
        bus_addr = OFS_STAT;
        wake_in[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 chk("R3 not yet", {31'd0, bus_rdata[5]}, 32'd0);
        @(negedge clk);
        #1 chk("R3 latched", {31'd0, bus_rdata[5]}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule